// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This engine moves received frames out of a byte-wide receive FIFO and into memory buffers. Software builds a circular list of descriptors in memory, each naming one buffer and its capacity. While the receive-enable input is high, the engine reads the next descriptor, waits for frame bytes, packs them into 32-bit words and writes them to the buffer. When the frame is finished, or when the buffer fills first, it writes a status word back into the descriptor. A frame larger than one buffer continues in the following descriptors.

Software hands a buffer back by setting its active bit again. The engine also keeps count of how many whole frames sit in the FIFO. It tells the FIFO's write side whether another frame may enter. A frame that arrives while the FIFO already holds the limit is refused and tallied in a saturating missed-frame counter, which clears when software reads it.

Top module: `rxdma_top`

## Requirements
- R1: After reset, memReq, fifoPop and frameIrq are 0, fifoRoom is 1 and missCount is 0.
- R2: The first fetch after reset reads the descriptor at listBase. Later fetches read the descriptor after the one used last. A fetch reads word 0 at +0, word 1 at +4 and word 2 at +8 from the descriptor address, and descriptors sit 16 bytes apart.
- R3: If word 0 bit 31 (active) is 0, no FIFO byte is popped and nothing is written. The engine reads word 0 again each time it finds frames waiting, and it resumes once the bit reads 1.
- R4: Frame bytes go to the buffer whose address is in word 2. Byte k of the buffer is bits 8*(k mod 4)+7:8*(k mod 4) of the 32-bit word at address buffer+4*floor(k/4).
- R5: Each buffer receives whole 16-byte units. Bytes past the data up to the next 16-byte boundary are written as zero, and nothing past that boundary is written.
- R6: Write-back puts {capacity, received length} into word 1, as bits 31:16 and 15:0. It then writes word 0 with bit 31 cleared and bit 30 (last) unchanged.
- R7: Word 0 bits 29:28 hold the position code: 10 for the start of a frame that continues, 00 for a middle part, 01 for an end part, and 11 for a whole frame in one buffer. A buffer that fills before the frame ends is closed with a code whose low bit is 0.
- R8: frameIrq pulses high for one cycle after the write-back that ends a frame. The write-back of a buffer that filled mid-frame gives no pulse.
- R9: After a descriptor whose word 0 bit 30 is 1, the next fetch reads listBase. Otherwise it reads the current address plus 16.
- R10: The frame count goes up on each accepted frameStart and down on each popped end-of-frame byte. fifoRoom is 1 exactly while the count is below 8. A frameStart that arrives while fifoRoom is 0 is not counted and adds one to missCount.
- R11: missCount saturates at 16'hFFFF. A missRead pulse clears it, and if a refused frame arrives in the same cycle the counter becomes 1.
- R12: An end byte flagged with fifoErr sets word 0 bit 27 and bit 0 in that frame's last write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| listBase | input | 32 | Byte address of the first descriptor in the ring |
| rxEnable | input | 1 | Receive enable; starts descriptor fetching |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle completion of the request |
| fifoValid | input | 1 | FIFO has a byte to pop |
| fifoData | input | 8 | FIFO head byte |
| fifoEof | input | 1 | Head byte ends its frame |
| fifoErr | input | 1 | Frame ended with an error (qualified by fifoEof) |
| fifoPop | output | 1 | Pop the FIFO head byte |
| frameStart | input | 1 | A new frame asks to enter the FIFO |
| fifoRoom | output | 1 | FIFO may accept another frame |
| frameIrq | output | 1 | Frame-received pulse |
| missRead | input | 1 | Read strobe for the missed-frame counter; clears it |
| missCount | output | 16 | Missed-frame counter |

## Verification
A refused frame and a counter read can land in the same cycle. Raising frameStart and missRead on the same edge while the FIFO is full must leave missCount at 1, so the clear must not swallow the new miss. A frame can also enter in the same cycle that the engine pops an end byte. The test fills the FIFO behind an inactive descriptor, then releases the descriptor and checks that fifoRoom returns once a frame drains. It also holds frameStart for more than 65535 cycles against a full FIFO and checks that missCount stops at its ceiling.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    OP_RD0, OP_RD1, OP_RD2, OP_DATA, OP_WB1, OP_WB0
  } memOp_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_WAIT, ST_POP, ST_DATA, ST_WB1, ST_WB0
  } rxState_t;

  typedef struct packed {
    logic   capW0;
    logic   capW1;
    logic   capW2;
    logic   popByte;
    logic   wordDone;
    logic   advance;
    memOp_t op;
  } ctlStrobe_t;
endpackage

// File: rtl/rxdma_tally.sv
module rxdma_tally #(
  parameter int MAX_FRAMES = 8,
  parameter int MISS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameStart,
  input  logic              eofPop,
  input  logic              missRead,
  output logic              fifoRoom,
  output logic              framesWaiting,
  output logic [MISS_W-1:0] missCount
);
  localparam int CNT_W = $clog2(MAX_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FRAMES);

  logic [CNT_W-1:0] frameCount;
  logic             accept, refuse;

  assign fifoRoom      = frameCount < CNT_MAX;
  assign framesWaiting = frameCount != '0;
  assign accept        = frameStart && fifoRoom;
  assign refuse        = frameStart && !fifoRoom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCount <= '0;
    end else if (accept && !(eofPop && framesWaiting)) begin
      frameCount <= frameCount + 1'b1;
    end else if (!accept && eofPop && framesWaiting) begin
      frameCount <= frameCount - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      missCount <= '0;
    end else if (missRead) begin
      missCount <= refuse ? MISS_W'(1) : '0;
    end else if (refuse && missCount != '1) begin
      missCount <= missCount + 1'b1;
    end
  end

  // R10: the count never passes its limit
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frameCount <= CNT_MAX);
  // R10: a refused frame is tallied
  a_r10_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !fifoRoom && !missRead && missCount != '1)
      |=> missCount == $past(missCount) + 1'b1);
  // R11: a read leaves at most the miss of the same cycle
  a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    missRead |=> missCount <= MISS_W'(1));
  // R11: saturation holds
  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (missCount == '1 && !missRead) |=> missCount == '1);
endmodule

// File: rtl/rxdma_ctl.sv
module rxdma_ctl
  import rxdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic       memAck,
  input  logic       rdActive,
  input  logic       fifoValid,
  input  logic       fifoEof,
  input  logic       framesWaiting,
  input  logic       eofSeen,
  input  logic       bufFull,
  input  logic       nextAligned,
  input  logic       wordLast,
  output ctlStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       fifoPop,
  output logic       frameIrq
);
  rxState_t state, stateNext;

  always_comb begin
    strb          = '0;
    strb.op       = OP_RD0;
    memReq        = 1'b0;
    memWe         = 1'b0;
    stateNext     = state;
    unique case (state)
      ST_IDLE: if (rxEnable) stateNext = ST_RD0;
      ST_RD0: begin
        memReq     = 1'b1;
        strb.op    = OP_RD0;
        strb.capW0 = memAck;
        if (memAck) stateNext = rdActive ? ST_RD1 : ST_WAIT;
      end
      ST_RD1: begin
        memReq     = 1'b1;
        strb.op    = OP_RD1;
        strb.capW1 = memAck;
        if (memAck) stateNext = ST_RD2;
      end
      ST_RD2: begin
        memReq     = 1'b1;
        strb.op    = OP_RD2;
        strb.capW2 = memAck;
        if (memAck) stateNext = ST_POP;
      end
      ST_WAIT: if (framesWaiting) stateNext = ST_RD0;
      ST_POP: begin
        strb.popByte = fifoValid;
        if (fifoValid && (wordLast || fifoEof)) stateNext = ST_DATA;
      end
      ST_DATA: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strb.op       = OP_DATA;
        strb.wordDone = memAck;
        if (memAck) begin
          if (eofSeen)      stateNext = nextAligned ? ST_WB1 : ST_DATA;
          else if (bufFull) stateNext = ST_WB1;
          else              stateNext = ST_POP;
        end
      end
      ST_WB1: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        strb.op = OP_WB1;
        if (memAck) stateNext = ST_WB0;
      end
      ST_WB0: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.op      = OP_WB0;
        strb.advance = memAck;
        if (memAck) stateNext = (eofSeen && !rxEnable) ? ST_IDLE : ST_RD0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign fifoPop = strb.popByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frameIrq <= 1'b0;
    end else begin
      state    <= stateNext;
      frameIrq <= (state == ST_WB0) && memAck && eofSeen;
    end
  end

  // R2: a memory request stays up and unchanged until acknowledged
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(strb.op)));
  // R8: the frame interrupt lasts one cycle
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frameIrq |=> !frameIrq);
endmodule

// File: rtl/rxdma_dp.sv
module rxdma_dp
  import rxdma_pkg::*;
#(
  parameter int DESC_STRIDE = 16,
  parameter int UNIT_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        fifoData,
  input  logic              fifoEof,
  input  logic              fifoErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              eofSeen,
  output logic              bufFull,
  output logic              nextAligned,
  output logic              wordLast
);
  localparam int UNIT_LSB = $clog2(UNIT_BYTES);
  localparam int LANE_W   = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] descPtr, curDesc, bufAddr;
  logic              ptrValid, descActive, lastBit, errSeen, startHere;
  logic [15:0]       cap, bufBytes, wrOff, offNext;
  logic [31:0]       wordBuf, wordMerged;
  logic [LANE_W-1:0] wordFill;

  assign curDesc     = ptrValid ? descPtr : listBase;
  assign offNext     = wrOff + 16'(WORD_BYTES);
  assign nextAligned = offNext[UNIT_LSB-1:0] == '0;
  assign bufFull     = bufBytes == cap;
  assign wordLast    = wordFill == LANE_W'(WORD_BYTES - 1);

  always_comb begin
    wordMerged = wordBuf;
    for (int l = 0; l < WORD_BYTES; l++)
      if (wordFill == LANE_W'(l)) wordMerged[8*l +: 8] = fifoData;
  end

  always_comb begin
    memAddr  = curDesc;
    memWdata = '0;
    unique case (strb.op)
      OP_RD0:  memAddr = curDesc;
      OP_RD1:  memAddr = curDesc + 32'd4;
      OP_RD2:  memAddr = curDesc + 32'd8;
      OP_DATA: begin
        memAddr  = bufAddr + {16'b0, wrOff};
        memWdata = wordBuf;
      end
      OP_WB1: begin
        memAddr  = curDesc + 32'd4;
        memWdata = {cap, bufBytes};
      end
      OP_WB0: begin
        memAddr  = curDesc;
        memWdata = {1'b0, lastBit, startHere, eofSeen, errSeen, 26'b0, errSeen};
      end
      default: memAddr = curDesc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      descPtr    <= '0;
      ptrValid   <= 1'b0;
      descActive <= 1'b0;
      lastBit    <= 1'b0;
      cap        <= '0;
      bufAddr    <= '0;
      bufBytes   <= '0;
      wrOff      <= '0;
      wordBuf    <= '0;
      wordFill   <= '0;
      eofSeen    <= 1'b0;
      errSeen    <= 1'b0;
      startHere  <= 1'b1;
    end else begin
      if (strb.capW0) begin
        descActive <= memRdata[31];
        lastBit    <= memRdata[30];
      end
      if (strb.capW1) cap <= memRdata[31:16];
      if (strb.capW2) begin
        bufAddr  <= memRdata;
        bufBytes <= '0;
        wrOff    <= '0;
        wordBuf  <= '0;
        wordFill <= '0;
      end
      if (strb.popByte) begin
        wordBuf  <= wordMerged;
        bufBytes <= bufBytes + 16'd1;
        wordFill <= wordFill + 1'b1;
        if (fifoEof) begin
          eofSeen <= 1'b1;
          errSeen <= fifoErr;
        end
      end
      if (strb.wordDone) begin
        wrOff    <= offNext;
        wordBuf  <= '0;
        wordFill <= '0;
      end
      if (strb.advance) begin
        descPtr    <= lastBit ? listBase : curDesc + ADDR_W'(DESC_STRIDE);
        ptrValid   <= 1'b1;
        descActive <= 1'b0;
        startHere  <= eofSeen;
        eofSeen    <= 1'b0;
        errSeen    <= 1'b0;
      end
    end
  end

  // R3: bytes are only popped into a buffer whose descriptor read active
  a_r3_pop_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    strb.popByte |-> descActive);
endmodule

// File: rtl/rxdma_top.sv
module rxdma_top
  import rxdma_pkg::*;
#(
  parameter int MAX_FRAMES  = 8,
  parameter int MISS_W      = 16,
  parameter int DESC_STRIDE = 16,
  parameter int UNIT_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       listBase,
  input  logic              rxEnable,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              fifoValid,
  input  logic [7:0]        fifoData,
  input  logic              fifoEof,
  input  logic              fifoErr,
  output logic              fifoPop,
  input  logic              frameStart,
  output logic              fifoRoom,
  output logic              frameIrq,
  input  logic              missRead,
  output logic [MISS_W-1:0] missCount
);
  ctlStrobe_t strb;
  logic framesWaiting, eofSeen, bufFull, nextAligned, wordLast;

  rxdma_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .memAck(memAck),
    .rdActive(memRdata[31]), .fifoValid(fifoValid), .fifoEof(fifoEof),
    .framesWaiting(framesWaiting), .eofSeen(eofSeen), .bufFull(bufFull),
    .nextAligned(nextAligned), .wordLast(wordLast), .strb(strb),
    .memReq(memReq), .memWe(memWe), .fifoPop(fifoPop), .frameIrq(frameIrq)
  );

  rxdma_dp #(.DESC_STRIDE(DESC_STRIDE), .UNIT_BYTES(UNIT_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .listBase(listBase),
    .memRdata(memRdata), .fifoData(fifoData), .fifoEof(fifoEof),
    .fifoErr(fifoErr), .memAddr(memAddr), .memWdata(memWdata),
    .eofSeen(eofSeen), .bufFull(bufFull), .nextAligned(nextAligned),
    .wordLast(wordLast)
  );

  rxdma_tally #(.MAX_FRAMES(MAX_FRAMES), .MISS_W(MISS_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart),
    .eofPop(fifoPop && fifoEof), .missRead(missRead), .fifoRoom(fifoRoom),
    .framesWaiting(framesWaiting), .missCount(missCount)
  );
endmodule

// File: tb/test_rxdma_top.sv
`timescale 1ns/1ps
module test_rxdma_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] listBase = 32'h100;
  logic        rxEnable = 1'b0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata = '0;
  logic        fifoValid, fifoEof, fifoErr, fifoPop;
  logic [7:0]  fifoData;
  logic        frameStart = 1'b0, fifoRoom, frameIrq, missRead = 1'b0;
  logic [15:0] missCount;

  rxdma_top i_rxdma_top (
    .clk(clk), .rst_n(rst_n), .listBase(listBase), .rxEnable(rxEnable),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .fifoValid(fifoValid),
    .fifoData(fifoData), .fifoEof(fifoEof), .fifoErr(fifoErr),
    .fifoPop(fifoPop), .frameStart(frameStart), .fifoRoom(fifoRoom),
    .frameIrq(frameIrq), .missRead(missRead), .missCount(missCount)
  );

  // memory model: one-cycle acknowledge
  logic [31:0] mem [0:255];
  int wrCount = 0;
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck   <= 1'b1;
      memRdata <= mem[memAddr[9:2]];
      if (memWe) begin
        mem[memAddr[9:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end
    end
  end

  // byte FIFO model
  logic [7:0]  qData [0:1023];
  logic        qEof  [0:1023];
  logic        qErr  [0:1023];
  logic [31:0] wrPtr = '0, rdPtr = '0;
  int popCount = 0, irqCount = 0;
  assign fifoValid = rdPtr != wrPtr;
  assign fifoData  = qData[rdPtr[9:0]];
  assign fifoEof   = qEof[rdPtr[9:0]];
  assign fifoErr   = qErr[rdPtr[9:0]];
  always @(posedge clk) begin
    if (fifoPop) begin
      rdPtr    <= rdPtr + 1;
      popCount <= popCount + 1;
    end
    if (frameIrq) irqCount <= irqCount + 1;
  end

  int testCount = 0, failCount = 0, descIdx = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int fid, input int k);
    return 8'((fid * 37 + k * 3 + 1) & 255);
  endfunction

  task automatic armDesc(input int i, input bit act);
    logic [31:0] d, b;
    d = 32'h100 + 32'(i * 16);
    b = 32'h200 + 32'(i * 32);
    mem[d[9:2]]       = {act, i == 3, 30'b0};
    mem[d[9:2] + 8'd1] = {16'd32, 16'd0};
    mem[d[9:2] + 8'd2] = b;
    for (int w = 0; w < 8; w++) mem[b[9:2] + 8'(w)] = 32'hEEEEEEEE;
  endtask

  task automatic pushFrame(input int fid, input int len, input bit err, output bit adm);
    adm = fifoRoom;
    frameStart = 1'b1;
    if (adm) begin
      for (int k = 0; k < len; k++) begin
        qData[wrPtr[9:0]] = pat(fid, k);
        qEof[wrPtr[9:0]]  = (k == len - 1);
        qErr[wrPtr[9:0]]  = err && (k == len - 1);
        wrPtr = wrPtr + 1;
      end
    end
    @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIrq(output bit got);
    got = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (frameIrq) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic checkFrame(input int fid, input int len, input bit err);
    int rem, off, c;
    rem = len; off = 0; c = 0;
    while (rem > 0) begin
      int chunk, rnd, mism, pad;
      bit fin;
      logic [31:0] d, b, w0, got;
      chunk = (rem > 32) ? 32 : rem;
      fin   = (rem == chunk);
      d = 32'h100 + 32'(descIdx * 16);
      b = 32'h200 + 32'(descIdx * 32);
      w0 = {1'b0, descIdx == 3, c == 0, fin, err && fin, 26'b0, err && fin};
      check(mem[d[9:2]] == w0, "R6", "status word", mem[d[9:2]], w0);
      check(mem[d[9:2]][29:28] == {c == 0, fin}, "R7", "position code",
            32'(mem[d[9:2]][29:28]), 32'({c == 0, fin}));
      if (err) check(mem[d[9:2]][27] == fin && mem[d[9:2]][0] == fin, "R12",
                     "error bits", mem[d[9:2]], w0);
      check(mem[d[9:2] + 8'd1] == {16'd32, 16'(chunk)}, "R6", "length word",
            mem[d[9:2] + 8'd1], {16'd32, 16'(chunk)});
      if (descIdx == 0 && fid != 0)
        check(mem[d[9:2] + 8'd1][15:0] == 16'(chunk), "R9", "wrapped descriptor",
              32'(mem[d[9:2] + 8'd1][15:0]), 32'(chunk));
      mism = 0;
      for (int k = 0; k < chunk; k++) begin
        got = b + 32'(k);
        if (mem[got[9:2]][8 * (k % 4) +: 8] != pat(fid, off + k)) mism++;
      end
      check(mism == 0, "R4", "buffer bytes mismatched", 32'(mism), 0);
      rnd = ((chunk + 15) / 16) * 16;
      pad = 0;
      for (int k = chunk; k < rnd; k++) begin
        got = b + 32'(k);
        if (mem[got[9:2]][8 * (k % 4) +: 8] != 8'h00) pad++;
      end
      check(pad == 0, "R5", "nonzero pad bytes", 32'(pad), 0);
      if (rnd < 32) begin
        got = b + 32'(rnd);
        check(mem[got[9:2]] == 32'hEEEEEEEE, "R5", "word past unit",
              mem[got[9:2]], 32'hEEEEEEEE);
      end
      armDesc(descIdx, 1'b1);
      descIdx = (descIdx + 1) % 4;
      rem -= chunk; off += chunk; c++;
    end
  endtask

  typedef struct packed { logic [15:0] len; logic err; } vec_t;
  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{16'd5,  1'b0},   // whole frame, padded
    '{16'd32, 1'b0},   // exactly one buffer
    '{16'd40, 1'b0},   // start + end, wraps past last descriptor
    '{16'd16, 1'b1},   // error frame
    '{16'd64, 1'b0}    // two full buffers
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testCount++; failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit adm, got;
    int popBase, wrBase, irqBase;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) armDesc(i, 1'b1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(memReq == 0, "R1", "memReq", 32'(memReq), 0);
    check(fifoPop == 0, "R1", "fifoPop", 32'(fifoPop), 0);
    check(frameIrq == 0, "R1", "frameIrq", 32'(frameIrq), 0);
    check(fifoRoom == 1, "R1", "fifoRoom", 32'(fifoRoom), 1);
    check(missCount == 0, "R1", "missCount", 32'(missCount), 0);

    rxEnable = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      irqBase = irqCount;
      pushFrame(v, int'(VEC[v].len), VEC[v].err, adm);
      if (v == NVEC - 1) rxEnable = 1'b0;
      waitIrq(got);
      check(got, "R8", "frame interrupt seen", 32'(got), 1);
      if (v == 0) check(mem[32'h100 >> 2][31] == 1'b0, "R2", "first fetch at base",
                        32'(mem[32'h100 >> 2][31]), 0);
      repeat (3) @(negedge clk);
      check(irqCount == irqBase + 1, "R8", "one pulse per frame",
            32'(irqCount - irqBase), 1);
      checkFrame(v, int'(VEC[v].len), VEC[v].err);
    end

    // inactive descriptor blocks draining; fill FIFO to its limit
    armDesc(descIdx, 1'b0);
    popBase = popCount;
    wrBase  = wrCount;
    rxEnable = 1'b1;
    for (int f = 0; f < 8; f++) begin
      pushFrame(10 + f, 4, 1'b0, adm);
      check(adm, "R10", "frame admitted below limit", 32'(adm), 1);
    end
    repeat (20) @(negedge clk);
    check(fifoRoom == 0, "R10", "fifoRoom at limit", 32'(fifoRoom), 0);
    check(popCount == popBase, "R3", "pops with inactive descriptor",
          32'(popCount - popBase), 0);
    check(wrCount == wrBase, "R3", "writes with inactive descriptor",
          32'(wrCount - wrBase), 0);
    pushFrame(90, 4, 1'b0, adm);
    pushFrame(91, 4, 1'b0, adm);
    check(missCount == 2, "R10", "refused frames counted", 32'(missCount), 2);
    // clear and a new miss in the same cycle
    missRead = 1'b1; frameStart = 1'b1;
    @(negedge clk);
    missRead = 1'b0; frameStart = 1'b0;
    @(negedge clk);
    check(missCount == 1, "R11", "read plus miss", 32'(missCount), 1);
    frameStart = 1'b1;
    repeat (65540) @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
    check(missCount == 16'hFFFF, "R11", "saturation", 32'(missCount), 32'hFFFF);
    missRead = 1'b1;
    @(negedge clk);
    missRead = 1'b0;
    @(negedge clk);
    check(missCount == 0, "R11", "cleared by read", 32'(missCount), 0);

    // release the descriptor: the engine polls and resumes
    mem[(32'h100 + 32'(descIdx * 16)) >> 2][31] = 1'b1;
    waitIrq(got);
    check(got, "R3", "resumed after activation", 32'(got), 1);
    check(fifoRoom == 1, "R10", "room back below limit", 32'(fifoRoom), 1);
    checkFrame(10, 4, 1'b0);
    check(missCount == 0, "R11", "no spurious miss", 32'(missCount), 0);

    summary();
    $finish;
  end
endmodule